// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Unit

This block produces two independent pulse-width-modulated outputs from one clock. Each channel counts prescaled ticks over a programmable cycle. Its output sits at the active level for a programmable number of leading ticks and at the inactive level for the rest of the cycle. The prescaler picks its ratio from a fixed table of irregular divisors through a 4-bit code. One code, combined with a bypass bit, makes the channel count on every input clock.

Software programs the block through a 32-bit word-addressed register port. One shared control word packs a 10-bit field per channel, placed every 15 bits. Each channel also has a word that holds its cycle length minus one and its duty length. Cycle and duty writes go to a shadow copy. The shadow reaches the counter only when the running cycle wraps, and a per-channel ready bit shows that such an update is waiting. Clearing a channel's enable lets the current cycle run to its end. Clearing its clock gate stops the channel at once. In single-pulse mode, setting the pulse bit yields exactly one cycle, after which the bit clears itself.

Top module: `dual_pwm_unit`

## Requirements
- R1: After reset, every register reads 0 and every `pwm_out` bit is 1, which is the inactive level while the active-level bit is 0.
- R2: The control word is at byte address 0, and channel n's word is at 4+4n. Channel n's control field starts at bit 15n and holds: code [3:0], enable 4, active level 5, clock gate 6, single-pulse mode 7, pulse 8 and bypass 9. A channel word reads back its shadow, with the cycle length minus one in [31:16] and the duty in [15:0]. Read data appears one clock after the address is presented. An address not aligned to a word reads 0 and ignores writes.
- R3: Codes 0..4 give tick periods of 120, 180, 240, 360 and 480 clocks. Codes 8..12 give 12000, 24000, 36000, 48000 and 72000. Code 15 with bypass 1 gives one tick per clock. A running channel repeats its cycle every ratio*(P+1) clocks.
- R4: Codes 5..7 and 13..14, and code 15 with bypass 0, never start the channel, so the output stays at the inactive level.
- R5: A cycle lasts P+1 ticks. The output is at the active level for the first D ticks and at the inactive level otherwise. Active level bit 1 means high while active; bit 0 inverts the output. An idle channel drives the inactive level. The output is registered, so it follows the counter by one clock.
- R6: D = 0 keeps the output inactive for the whole cycle. D >= P+1 keeps it active for the whole cycle.
- R7: A channel-word write lands in the shadow and sets ready bit 28+n. The shadow loads at the next cycle wrap, or on the next clock if the channel is idle, and the ready bit then clears.
- R8: Clearing enable while a cycle runs lets that cycle finish at its normal timing; the channel then stays idle.
- R9: Clearing the clock gate stops the channel on the next clock edge, and the output goes inactive one clock later.
- R10: A control write changes a channel's code only if that channel's stored clock gate is 0. The other bits of the same write still take effect.
- R11: With single-pulse mode set, enable and gate set, and the pulse bit set, exactly one cycle is produced. The pulse bit then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | AW | Byte address of the register word |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data for the address of the previous clock |
| pwm_out | output | NCH | Registered PWM outputs, one per channel |

## Verification
The counter is tried with the one-tick bypass, a 120-clock ratio and a 12000-clock ratio. Measuring the clocks between rising edges separates the prescaler choice from the cycle length. Duties of 0, 1 and beyond the cycle, in both polarities, separate the compare boundary from the polarity inversion. Cycle words are written while a channel runs and while it is idle, which shows whether a load is deferred or immediate. Enable and gate are cleared mid-cycle, a code change is attempted with the gate set, and single pulses are fired twice. Together these show which stop path, guard or self-clear the design took.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  localparam int RATIO_W = 17;
  localparam int FLD_W   = 10;

  typedef struct packed {
    logic       byp;
    logic       pulse;
    logic       mode;
    logic       gate;
    logic       lvl;
    logic       en;
    logic [3:0] code;
  } chfld_t;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [3:0] code, input logic byp);
    logic [RATIO_W-1:0] r;
    case (code)
      4'd0:    r = RATIO_W'(120);
      4'd1:    r = RATIO_W'(180);
      4'd2:    r = RATIO_W'(240);
      4'd3:    r = RATIO_W'(360);
      4'd4:    r = RATIO_W'(480);
      4'd8:    r = RATIO_W'(12000);
      4'd9:    r = RATIO_W'(24000);
      4'd10:   r = RATIO_W'(36000);
      4'd11:   r = RATIO_W'(48000);
      4'd12:   r = RATIO_W'(72000);
      4'd15:   r = byp ? RATIO_W'(1) : '0;
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dpwm_tick.sv
module dpwm_tick #(
  parameter int RW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [RW-1:0] ratio,
  output logic          tick
);
  logic [RW-1:0] dcnt;

  assign tick = run && (dcnt == ratio - RW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) dcnt <= '0;
    else if (tick)   dcnt <= '0;
    else             dcnt <= dcnt + RW'(1);
  end
endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ok,
  input  logic          start,
  input  logic          stay,
  input  logic          lvl,
  input  logic          tick,
  input  logic          wr,
  input  logic [CW-1:0] wr_prd,
  input  logic [CW-1:0] wr_dty,
  output logic          live,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] aprd,
  output logic [CW-1:0] adty,
  output logic [CW-1:0] sh_prd,
  output logic [CW-1:0] sh_dty,
  output logic          pend,
  output logic          wrap,
  output logic          pout
);
  assign wrap = ok && tick && (cnt == aprd);

  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= 1'b0;
      cnt    <= '0;
      aprd   <= '0;
      adty   <= '0;
      sh_prd <= '0;
      sh_dty <= '0;
      pend   <= 1'b0;
      pout   <= 1'b1;
    end else begin
      pout <= (live && (cnt < adty)) ? lvl : ~lvl;
      if (!ok) begin
        live <= 1'b0;
        cnt  <= '0;
      end else if (!live) begin
        cnt <= '0;
        if (start) live <= 1'b1;
      end else if (tick) begin
        if (cnt == aprd) begin
          cnt <= '0;
          if (!stay) live <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
      if ((wrap || !live) && pend) begin
        aprd <= sh_prd;
        adty <= sh_dty;
        pend <= 1'b0;
      end
      if (wr) begin
        sh_prd <= wr_prd;
        sh_dty <= wr_dty;
        pend   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_pwm_unit.sv
module dual_pwm_unit
  import dpwm_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int CW      = 16,
  parameter int AW      = 4,
  parameter int DW      = 32,
  parameter bit HAS_BYP = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int STRIDE   = 15;
  localparam int RDY_BASE = 28;
  localparam int PRD_LSB  = 16;
  localparam int IDXW     = AW - 2;

  chfld_t fld  [NCH];
  chfld_t nfld [NCH];

  logic [NCH-1:0]    live, wrap, pend, chan_wr, okv;
  logic [NCH-1:0]    gate, lvl, mode, pulse;
  logic [NCH*CW-1:0] cnt_f, aprd_f, adty_f, sh_prd_f, sh_dty_f;
  logic [IDXW-1:0]   idx;
  logic              aligned, ctl_wr;
  logic [DW-1:0]     img, rd_next;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign idx     = bus_addr[AW-1:2];
  assign ctl_wr  = bus_we && aligned && (idx == '0);

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      nfld[n] = chfld_t'(bus_wdata[STRIDE*n +: FLD_W]);
      if (fld[n].gate) nfld[n].code = fld[n].code;
    end
  end

  always_ff @(posedge clk) begin
    for (int n = 0; n < NCH; n++) begin
      if (rst) begin
        fld[n] <= '0;
      end else begin
        if (wrap[n] && fld[n].mode) fld[n].pulse <= 1'b0;
        if (ctl_wr) fld[n] <= nfld[n];
      end
    end
  end

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic [RATIO_W-1:0] ratio;
      logic               tick;

      assign gate[n]    = fld[n].gate;
      assign lvl[n]     = fld[n].lvl;
      assign mode[n]    = fld[n].mode;
      assign pulse[n]   = fld[n].pulse;
      assign ratio      = ratio_of(fld[n].code, fld[n].byp && HAS_BYP);
      assign okv[n]     = fld[n].gate && (ratio != '0);
      assign chan_wr[n] = bus_we && aligned && (idx == IDXW'(n + 1));

      dpwm_tick #(.RW(RATIO_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .run   (live[n] && okv[n]),
        .ratio (ratio),
        .tick  (tick)
      );

      dpwm_chan #(.CW(CW)) u_chan (
        .clk    (clk),
        .rst    (rst),
        .ok     (okv[n]),
        .start  (fld[n].en && (fld[n].mode ? fld[n].pulse : 1'b1)),
        .stay   (fld[n].en && !fld[n].mode),
        .lvl    (fld[n].lvl),
        .tick   (tick),
        .wr     (chan_wr[n]),
        .wr_prd (bus_wdata[PRD_LSB +: CW]),
        .wr_dty (bus_wdata[CW-1:0]),
        .live   (live[n]),
        .cnt    (cnt_f[CW*n +: CW]),
        .aprd   (aprd_f[CW*n +: CW]),
        .adty   (adty_f[CW*n +: CW]),
        .sh_prd (sh_prd_f[CW*n +: CW]),
        .sh_dty (sh_dty_f[CW*n +: CW]),
        .pend   (pend[n]),
        .wrap   (wrap[n]),
        .pout   (pwm_out[n])
      );
    end
  endgenerate

  always_comb begin
    img = '0;
    for (int n = 0; n < NCH; n++) begin
      img[STRIDE*n +: FLD_W] = fld[n];
      img[RDY_BASE + n]      = pend[n];
    end
  end

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (idx == '0) rd_next = img;
      for (int n = 0; n < NCH; n++) begin
        if (idx == IDXW'(n + 1)) begin
          rd_next[PRD_LSB +: CW] = sh_prd_f[CW*n +: CW];
          rd_next[CW-1:0]        = sh_dty_f[CW*n +: CW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
  parameter int NCH = 2,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    live,
  input logic [NCH-1:0]    wrap,
  input logic [NCH-1:0]    pend,
  input logic [NCH-1:0]    chan_wr,
  input logic              ctl_wr,
  input logic [NCH-1:0]    gate,
  input logic [NCH-1:0]    lvl,
  input logic [NCH-1:0]    mode,
  input logic [NCH-1:0]    pulse,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH*CW-1:0] cnt_f,
  input logic [NCH*CW-1:0] aprd_f,
  input logic [NCH*CW-1:0] adty_f
);
  generate
    for (genvar n = 0; n < NCH; n++) begin : g_chk
      p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
        !live[n] |=> pwm_out[n] == !$past(lvl[n]));

      p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        live[n] |-> cnt_f[CW*n +: CW] <= aprd_f[CW*n +: CW]);

      p_full_duty_r6: assert property (@(posedge clk) disable iff (rst)
        (live[n] && (adty_f[CW*n +: CW] > aprd_f[CW*n +: CW])) |=> pwm_out[n] == $past(lvl[n]));

      p_hold_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (pend[n] && live[n] && !wrap[n] && !chan_wr[n]) |=> pend[n]);

      p_gate_stop_r9: assert property (@(posedge clk) disable iff (rst)
        !gate[n] |=> !live[n]);

      p_pulse_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (wrap[n] && mode[n] && !ctl_wr) |=> !pulse[n]);
    end
  endgenerate
endmodule

bind dual_pwm_unit dpwm_checker #(.NCH(NCH), .CW(CW)) i_dpwm_checker (
  .clk     (clk),
  .rst     (rst),
  .live    (live),
  .wrap    (wrap),
  .pend    (pend),
  .chan_wr (chan_wr),
  .ctl_wr  (ctl_wr),
  .gate    (gate),
  .lvl     (lvl),
  .mode    (mode),
  .pulse   (pulse),
  .pwm_out (pwm_out),
  .cnt_f   (cnt_f),
  .aprd_f  (aprd_f),
  .adty_f  (adty_f)
);

// File: tb/test_dual_pwm_unit.sv
module test_dual_pwm_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  dual_pwm_unit i_dual_pwm_unit (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // ---------------- behavioural reference model ----------------
  int m_fld[2], m_live[2], m_cnt[2], m_dcnt[2];
  int m_aprd[2], m_adty[2], m_sprd[2], m_sdty[2], m_pend[2];
  logic [1:0]  e_out = 2'b11;
  logic [31:0] e_rd = 32'd0;

  function automatic int bench_ratio(int code, int byp);
    int tbl[16] = '{120, 180, 240, 360, 480, 0, 0, 0,
                    12000, 24000, 36000, 48000, 72000, 0, 0, 0};
    if (code == 15) return byp ? 1 : 0;
    return tbl[code];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < 2; n++) begin
        m_fld[n] = 0; m_live[n] = 0; m_cnt[n] = 0; m_dcnt[n] = 0;
        m_aprd[n] = 0; m_adty[n] = 0; m_sprd[n] = 0; m_sdty[n] = 0; m_pend[n] = 0;
      end
      e_out = 2'b11;
      e_rd  = 32'd0;
    end else begin
      int old_fld[2];
      int wrapv[2];
      e_rd = 32'd0;
      if (bus_addr[1:0] == 2'b00) begin
        if (bus_addr[3:2] == 2'd0) begin
          for (int n = 0; n < 2; n++) begin
            e_rd = e_rd | (32'(m_fld[n]) << (15 * n));
            if (m_pend[n] != 0) e_rd[28 + n] = 1'b1;
          end
        end else if (bus_addr[3:2] <= 2'd2) begin
          int k;
          k = int'(bus_addr[3:2]) - 1;
          e_rd = (32'(m_sprd[k]) << 16) | 32'(m_sdty[k]);
        end
      end
      for (int n = 0; n < 2; n++) begin
        int lv;
        lv = (m_fld[n] >> 5) & 1;
        e_out[n] = (m_live[n] != 0 && m_cnt[n] < m_adty[n]) ? lv[0] : !lv[0];
        old_fld[n] = m_fld[n];
      end
      for (int n = 0; n < 2; n++) begin
        int f, en, gt, md, pl, r, ok, tk, old_live;
        f = old_fld[n];
        en = (f >> 4) & 1; gt = (f >> 6) & 1; md = (f >> 7) & 1; pl = (f >> 8) & 1;
        r = bench_ratio(f & 15, (f >> 9) & 1);
        ok = (gt != 0 && r != 0) ? 1 : 0;
        old_live = m_live[n];
        tk = (old_live != 0 && ok != 0 && m_dcnt[n] == r - 1) ? 1 : 0;
        wrapv[n] = (tk != 0 && m_cnt[n] == m_aprd[n]) ? 1 : 0;
        if (old_live != 0 && ok != 0) m_dcnt[n] = (tk != 0) ? 0 : m_dcnt[n] + 1;
        else m_dcnt[n] = 0;
        if (ok == 0) begin
          m_live[n] = 0; m_cnt[n] = 0;
        end else if (old_live == 0) begin
          m_cnt[n] = 0;
          if (en != 0 && (md != 0 ? pl != 0 : 1'b1)) m_live[n] = 1;
        end else if (tk != 0) begin
          if (wrapv[n] != 0) begin
            m_cnt[n] = 0;
            if (en == 0 || md != 0) m_live[n] = 0;
          end else m_cnt[n] = m_cnt[n] + 1;
        end
        if ((wrapv[n] != 0 || old_live == 0) && m_pend[n] != 0) begin
          m_aprd[n] = m_sprd[n]; m_adty[n] = m_sdty[n]; m_pend[n] = 0;
        end
        if (bus_we && bus_addr[1:0] == 2'b00 && int'(bus_addr[3:2]) == n + 1) begin
          m_sprd[n] = int'(bus_wdata[31:16]); m_sdty[n] = int'(bus_wdata[15:0]); m_pend[n] = 1;
        end
      end
      for (int n = 0; n < 2; n++) begin
        if (wrapv[n] != 0 && ((old_fld[n] >> 7) & 1) != 0) m_fld[n] = m_fld[n] & ~(1 << 8);
        if (bus_we && bus_addr == 4'd0) begin
          int nf;
          nf = int'((bus_wdata >> (15 * n)) & 32'h3FF);
          if (((old_fld[n] >> 6) & 1) != 0) nf = (nf & ~15) | (old_fld[n] & 15);
          m_fld[n] = nf;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int n = 0; n < 2; n++) begin
        checks++;
        if (pwm_out[n] !== e_out[n]) begin
          errors++;
          $display("FAIL %s pwm_out[%0d] actual %0b expected %0b at %0t", tag, n, pwm_out[n], e_out[n], $time);
        end
      end
      checks++;
      if (bus_rdata !== e_rd) begin
        errors++;
        $display("FAIL %s bus_rdata actual %h expected %h at %0t", tag, bus_rdata, e_rd, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d (0x%h) expected %0d (0x%h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'd0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = int'(bus_rdata);
    bus_addr = 4'd0;
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    prev = pwm_out[ch];
    forever begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
    end
  endtask

  task automatic measure(input int ch, output int cyc);
    logic prev;
    wait_rise(ch);
    cyc = 0;
    prev = pwm_out[ch];
    forever begin
      @(negedge clk);
      cyc++;
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
    end
  endtask

  task automatic count_high(input int ch, input int win, output int h);
    h = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) h++;
    end
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog %s actual hung expected finished", tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    tag = "R1";
    check("R1 reset output", int'(pwm_out), 3);
    rd_reg(4'd0, v); check("R1 reset control", v, 0);
    rd_reg(4'd4, v); check("R1 reset channel word", v, 0);

    // bypass, cycle 4 ticks, duty 1
    tag = "R3";
    wr_reg(4'd4, {16'd3, 16'd1});
    wr_reg(4'd0, 32'h27F);
    measure(0, v); check("R3 bypass cycle length", v, 4);
    tag = "R5";
    count_high(0, 8, v); check("R5 duty 1 of 4", v, 2);
    tag = "R2";
    rd_reg(4'd0, v); check("R2 control readback", v, 32'h27F);
    rd_reg(4'd4, v); check("R2 shadow readback", v, 32'h0003_0001);
    rd_reg(4'd2, v); check("R2 misaligned read", v, 0);

    // shadow and ready flag
    tag = "R7";
    wr_reg(4'd4, {16'd3, 16'd3});
    rd_reg(4'd0, v); check("R7 ready set while pending", v, 32'h1000_027F);
    idle(10);
    rd_reg(4'd0, v); check("R7 ready cleared after wrap", v, 32'h27F);

    // duty extremes
    tag = "R6";
    wr_reg(4'd4, {16'd3, 16'd0});
    idle(10);
    count_high(0, 8, v); check("R6 duty zero", v, 0);
    wr_reg(4'd4, {16'd3, 16'd4});
    idle(10);
    count_high(0, 8, v); check("R6 duty beyond cycle", v, 8);

    // inverted polarity
    tag = "R5";
    wr_reg(4'd4, {16'd3, 16'd1});
    wr_reg(4'd0, 32'h25F);
    idle(10);
    count_high(0, 8, v); check("R5 inverted level", v, 6);

    // enable clear mid-cycle
    tag = "R8";
    wr_reg(4'd0, 32'h27F);
    wr_reg(4'd4, {16'd9, 16'd5});
    idle(30);
    wait_rise(0);
    wr_reg(4'd0, 32'h26F);
    count_high(0, 20, v); check("R8 cycle completes", v, 2);
    count_high(0, 20, v); check("R8 idle after cycle", v, 0);

    // gate clear mid-cycle
    tag = "R9";
    wr_reg(4'd0, 32'h27F);
    idle(25);
    wait_rise(0);
    wr_reg(4'd0, 32'h23F);
    count_high(0, 20, v); check("R9 gate stops at once", v, 1);

    // code guard
    tag = "R10";
    wr_reg(4'd0, 32'h27F);
    idle(5);
    wr_reg(4'd0, 32'h270);
    rd_reg(4'd0, v); check("R10 code kept while gated on", v, 32'h27F);
    wr_reg(4'd0, 32'h23F);
    wr_reg(4'd4, {16'd3, 16'd1});
    wr_reg(4'd0, 32'h270);
    rd_reg(4'd0, v); check("R10 code taken while gate off", v, 32'h270);
    tag = "R3";
    measure(0, v); check("R3 ratio 120", v, 480);

    // invalid codes
    tag = "R4";
    wr_reg(4'd0, 32'h035);
    wr_reg(4'd0, 32'h075);
    count_high(0, 50, v); check("R4 code 5 stops", v, 0);
    wr_reg(4'd0, 32'h03F);
    wr_reg(4'd0, 32'h07F);
    count_high(0, 50, v); check("R4 code 15 without bypass", v, 0);

    // large ratio
    tag = "R3";
    wr_reg(4'd0, 32'h038);
    wr_reg(4'd4, {16'd1, 16'd1});
    wr_reg(4'd0, 32'h078);
    measure(0, v); check("R3 ratio 12000", v, 24000);

    // single pulse on channel 1
    tag = "R11";
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd8, {16'd4, 16'd2});
    wr_reg(4'd0, 32'h3FF << 15);
    count_high(1, 30, v); check("R11 one pulse", v, 2);
    rd_reg(4'd0, v); check("R11 pulse bit cleared", v, 32'h2FF << 15);
    wr_reg(4'd0, 32'h3FF << 15);
    count_high(1, 30, v); check("R11 second pulse", v, 2);
    check("R5 channel 0 idle inactive", int'(pwm_out[0]), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule